// File: doc/BRIEF.md
# Word-Select Frame Generator for a Master Serial Audio Link

This block produces the left/right word-select framing that a serial audio transmitter drives when it owns the link timing. Its time base is one-cycle pulses on `bclk_tick`. The surrounding logic raises `bclk_tick` once for every falling edge of the bit clock. Each pulse moves the generator one bit position forward inside the current half-frame.

The length of each half-frame comes from a programmed value, `chan_bits_m1`, which holds the number of bit clocks per channel minus one. Software sets it to the bit-clock rate divided by twice the sample rate, minus one. Sometimes that division leaves a remainder. For that case the uneven mode stretches the right half-frame by one bit clock, so the two halves together match the real frame length.

Two pulses go with `ws`. `chan_start` marks the first bit of every half-frame. `half_strobe` marks the last bit. Changes to the configuration are taken only where a right half-frame ends, so no frame ever mixes two settings. When `master_en` is low, the generator is idle and holds `ws` at the left-channel level.

Top module: `lrclk_frame_gen`

## Requirements
- R1: After reset, `ws` equals `left_is_high`, and `chan_start` and `half_strobe` are low.
- R2: While `master_en` is low, `bclk_tick` pulses produce no `chan_start` and no `half_strobe`, and `ws` stays at the left level.
- R3: In symmetric mode (`uneven_en`=0), each half-frame lasts `chan_bits_m1`+1 ticks. `ws` changes only in the cycle where `chan_start` is high.
- R4: With `uneven_en`=1, the left half-frame lasts `chan_bits_m1`+1 ticks and the right half-frame lasts `chan_bits_m1`+2 ticks.
- R5: Level encoding: with `left_is_high`=1, `ws` is 1 during the left half-frame and 0 during the right. With `left_is_high`=0, the levels are the other way round.
- R6: `chan_start` is high for exactly the one cycle after the tick that begins bit 0 of a half-frame. The first half-frame after `master_en` rises (on the first tick) is a left one.
- R7: `half_strobe` is high for the one cycle after the tick that begins the last bit of a half-frame. With a one-bit half-frame (`chan_bits_m1`=0, symmetric), it coincides with `chan_start` on every tick.
- R8: Changes to `chan_bits_m1`, `uneven_en` or `left_is_high` made while running take effect only from the next left half-frame.
- R9: `ws` and both pulse outputs change only after a clock edge on which `bclk_tick` was high, apart from entry into idle.
- R10: Deasserting `master_en` returns the generator to idle one clock later: `ws` at the left level, pulses low, and further ticks ignored.
- R11: The largest count, `chan_bits_m1`=2047, gives half-frames of 2048 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_tick | input | 1 | One-cycle pulse per bit-clock falling edge |
| master_en | input | 1 | Run the generator; low keeps it idle |
| left_is_high | input | 1 | 1: left channel is `ws` high; 0: left channel is `ws` low |
| chan_bits_m1 | input | CNT_W | Bit clocks per channel minus one |
| uneven_en | input | 1 | Lengthen the right half-frame by one tick |
| ws | output | 1 | Word-select |
| chan_start | output | 1 | First bit of a half-frame |
| half_strobe | output | 1 | Last bit of a half-frame |

## Verification
The bench measures each half-frame length in ticks under symmetric mode, uneven mode, the one-bit case and the 2047 maximum. An off-by-one counter or a missing stretch of the right half would show up as a wrong length there. It reprograms the count, the mode and the polarity in the middle of a frame. A design that loads settings early would give the current right half the new length or the new level. It also drops `master_en` during a right half-frame, with ticks spaced apart. A design that idles only at a boundary, or that moves `ws` between ticks, would leave `ws` low or produce stray pulses.

// File: rtl/lrclk_pkg.sv
package lrclk_pkg;

    typedef enum logic {
        SIDE_LEFT  = 1'b0,
        SIDE_RIGHT = 1'b1
    } side_e;

    typedef struct packed {
        logic chan_start;
        logic half_last;
    } lrc_pulse_t;

    function automatic side_e other_side(input side_e s);
        return (s == SIDE_LEFT) ? SIDE_RIGHT : SIDE_LEFT;
    endfunction

    function automatic logic ws_level(input side_e s, input logic left_high);
        return (s == SIDE_LEFT) ? left_high : !left_high;
    endfunction

endpackage

// File: rtl/lrclk_cfg_hold.sv
module lrclk_cfg_hold #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] in_bits,
    input  logic             in_uneven,
    input  logic             in_lhigh,
    output logic [CNT_W-1:0] q_bits,
    output logic             q_uneven,
    output logic [CNT_W-1:0] eff_bits,
    output logic             eff_uneven,
    output logic             eff_lhigh
);
    logic q_lhigh;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_bits   <= '0;
            q_uneven <= 1'b0;
            q_lhigh  <= 1'b1;
        end else if (load) begin
            q_bits   <= in_bits;
            q_uneven <= in_uneven;
            q_lhigh  <= in_lhigh;
        end
    end

    // Settings that apply from this edge onward
    always_comb begin
        eff_bits   = load ? in_bits   : q_bits;
        eff_uneven = load ? in_uneven : q_uneven;
        eff_lhigh  = load ? in_lhigh  : q_lhigh;
    end

endmodule

// File: rtl/lrclk_seq.sv
module lrclk_seq
    import lrclk_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             master_en,
    input  logic             live_lhigh,
    input  logic [CNT_W-1:0] q_bits,
    input  logic             q_uneven,
    input  logic [CNT_W-1:0] eff_bits,
    input  logic             eff_uneven,
    input  logic             eff_lhigh,
    output logic             load,
    output logic             ws,
    output lrc_pulse_t       pulse
);
    localparam int POS_W = CNT_W + 1;

    side_e            side_q;
    side_e            side_nx;
    logic             running_q;
    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] pos_inc;
    logic [POS_W-1:0] cur_last;
    logic             at_end;
    logic             ws_q;
    lrc_pulse_t       pulse_q;

    function automatic logic [POS_W-1:0] last_of(input side_e s,
                                                 input logic [CNT_W-1:0] b,
                                                 input logic u);
        return {1'b0, b} + ((s == SIDE_RIGHT && u) ? POS_W'(1) : POS_W'(0));
    endfunction

    always_comb begin
        cur_last = last_of(side_q, q_bits, q_uneven);
        at_end   = (pos_q == cur_last);
        pos_inc  = pos_q + POS_W'(1);
        side_nx  = other_side(side_q);
        load     = master_en && tick &&
                   (!running_q || (at_end && side_q == SIDE_RIGHT));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            running_q <= 1'b0;
            side_q    <= SIDE_LEFT;
            pos_q     <= '0;
            ws_q      <= live_lhigh;
            pulse_q   <= '0;
        end else begin
            pulse_q <= '0;
            if (!master_en) begin
                running_q <= 1'b0;
                side_q    <= SIDE_LEFT;
                pos_q     <= '0;
                ws_q      <= live_lhigh;
            end else if (!running_q) begin
                if (tick) begin
                    running_q         <= 1'b1;
                    side_q            <= SIDE_LEFT;
                    pos_q             <= '0;
                    ws_q              <= ws_level(SIDE_LEFT, eff_lhigh);
                    pulse_q.chan_start <= 1'b1;
                    pulse_q.half_last  <= (eff_bits == '0);
                end else begin
                    ws_q <= live_lhigh;
                end
            end else if (tick) begin
                if (at_end) begin
                    side_q            <= side_nx;
                    pos_q             <= '0;
                    ws_q              <= ws_level(side_nx, eff_lhigh);
                    pulse_q.chan_start <= 1'b1;
                    pulse_q.half_last  <=
                        (last_of(side_nx, eff_bits, eff_uneven) == '0);
                end else begin
                    pos_q             <= pos_inc;
                    pulse_q.half_last <= (pos_inc == cur_last);
                end
            end
        end
    end

    assign ws    = ws_q;
    assign pulse = pulse_q;

endmodule

// File: rtl/lrclk_frame_gen.sv
module lrclk_frame_gen
    import lrclk_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bclk_tick,
    input  logic             master_en,
    input  logic             left_is_high,
    input  logic [CNT_W-1:0] chan_bits_m1,
    input  logic             uneven_en,
    output logic             ws,
    output logic             chan_start,
    output logic             half_strobe
);
    logic             cfg_load;
    logic [CNT_W-1:0] q_bits;
    logic             q_uneven;
    logic [CNT_W-1:0] eff_bits;
    logic             eff_uneven;
    logic             eff_lhigh;
    lrc_pulse_t       pulse;

    lrclk_cfg_hold #(.CNT_W(CNT_W)) cfg_i (
        .clk        (clk),
        .rst        (rst),
        .load       (cfg_load),
        .in_bits    (chan_bits_m1),
        .in_uneven  (uneven_en),
        .in_lhigh   (left_is_high),
        .q_bits     (q_bits),
        .q_uneven   (q_uneven),
        .eff_bits   (eff_bits),
        .eff_uneven (eff_uneven),
        .eff_lhigh  (eff_lhigh)
    );

    lrclk_seq #(.CNT_W(CNT_W)) seq_i (
        .clk        (clk),
        .rst        (rst),
        .tick       (bclk_tick),
        .master_en  (master_en),
        .live_lhigh (left_is_high),
        .q_bits     (q_bits),
        .q_uneven   (q_uneven),
        .eff_bits   (eff_bits),
        .eff_uneven (eff_uneven),
        .eff_lhigh  (eff_lhigh),
        .load       (cfg_load),
        .ws         (ws),
        .pulse      (pulse)
    );

    assign chan_start  = pulse.chan_start;
    assign half_strobe = pulse.half_last;

endmodule

// File: rtl/lrclk_frame_gen_chk.sv
module lrclk_frame_gen_chk (
    input logic clk,
    input logic rst,
    input logic bclk_tick,
    input logic master_en,
    input logic left_is_high,
    input logic ws,
    input logic chan_start,
    input logic half_strobe
);
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !master_en |=> (!chan_start && !half_strobe));

    p_idle_left_r10: assert property (@(posedge clk) disable iff (rst)
        !master_en |=> (ws == $past(left_is_high)));

    p_start_after_tick_r6: assert property (@(posedge clk) disable iff (rst)
        chan_start |-> $past(bclk_tick));

    p_last_after_tick_r7: assert property (@(posedge clk) disable iff (rst)
        half_strobe |-> $past(bclk_tick));

    p_ws_moves_with_start_r3: assert property (@(posedge clk) disable iff (rst)
        (master_en && $past(master_en) && $stable(left_is_high) &&
         ws != $past(ws)) |-> chan_start);

endmodule

bind lrclk_frame_gen lrclk_frame_gen_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .bclk_tick    (bclk_tick),
    .master_en    (master_en),
    .left_is_high (left_is_high),
    .ws           (ws),
    .chan_start   (chan_start),
    .half_strobe  (half_strobe)
);

// File: tb/lrclk_frame_gen_tb.sv
module lrclk_frame_gen_tb_top;
    localparam int CNT_W = 11;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bclk_tick = 1'b0;
    logic             master_en = 1'b0;
    logic             left_is_high = 1'b1;
    logic [CNT_W-1:0] chan_bits_m1 = '0;
    logic             uneven_en = 1'b0;
    logic             ws;
    logic             chan_start;
    logic             half_strobe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    lrclk_frame_gen #(.CNT_W(CNT_W)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .bclk_tick    (bclk_tick),
        .master_en    (master_en),
        .left_is_high (left_is_high),
        .chan_bits_m1 (chan_bits_m1),
        .uneven_en    (uneven_en),
        .ws           (ws),
        .chan_start   (chan_start),
        .half_strobe  (half_strobe)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input logic t);
        bclk_tick = t;
        @(negedge clk);
    endtask

    // One tick followed by a gap cycle; the gap must not move anything (R9)
    task automatic bit_step(output logic cs, output logic hs, output logic w,
                            inout bit gap_bad);
        cyc(1'b1);
        cs = chan_start;
        hs = half_strobe;
        w  = ws;
        cyc(1'b0);
        if (chan_start || half_strobe || ws != w) gap_bad = 1'b1;
    endtask

    task automatic measure_half(input int exp_len, input logic exp_ws,
                                input string req);
        logic cs, hs, w;
        bit gap_bad = 1'b0;
        int n = 0;
        int hs_at = -1;
        do begin
            bit_step(cs, hs, w, gap_bad);
            n++;
            if (hs && !cs) hs_at = n;
        end while (!cs && n < 5000);
        check({req, " half length"}, n, exp_len);
        check({req, " ws of next half"}, w, exp_ws);
        check("R7 half_strobe on last bit", hs_at, exp_len - 1);
        check("R9 quiet between ticks", gap_bad, 0);
    endtask

    task automatic begin_run(input int n, input logic un, input logic lh);
        logic cs, hs, w;
        bit gap_bad = 1'b0;
        chan_bits_m1 = CNT_W'(n);
        uneven_en    = un;
        left_is_high = lh;
        master_en    = 1'b1;
        bit_step(cs, hs, w, gap_bad);
        check("R6 chan_start on first tick", cs, 1);
        check("R6 first half is left", w, lh);
        check("R7 strobe on first bit", hs, (n == 0) ? 1 : 0);
    endtask

    task automatic stop_run();
        master_en = 1'b0;
        cyc(1'b0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) cyc(1'b0);
        rst = 1'b0;
        cyc(1'b0);
        check("R1 ws after reset", ws, 1);
        check("R1 chan_start after reset", chan_start, 0);
        check("R1 half_strobe after reset", half_strobe, 0);
    endtask

    task automatic t_idle();
        logic cs, hs, w;
        bit gap_bad = 1'b0;
        int pulses = 0;
        int bad_ws = 0;
        chan_bits_m1 = CNT_W'(1);
        for (int i = 0; i < 8; i++) begin
            bit_step(cs, hs, w, gap_bad);
            if (cs || hs) pulses++;
            if (w != 1'b1) bad_ws++;
        end
        check("R2 no pulses while idle", pulses, 0);
        check("R2 ws left while idle", bad_ws, 0);
    endtask

    task automatic t_sym();
        begin_run(3, 1'b0, 1'b1);
        measure_half(4, 1'b0, "R3 left");
        measure_half(4, 1'b1, "R3 right");
        measure_half(4, 1'b0, "R3 left again");
        stop_run();
    endtask

    task automatic t_uneven();
        begin_run(3, 1'b1, 1'b1);
        measure_half(4, 1'b0, "R4 left");
        measure_half(5, 1'b1, "R4 right");
        measure_half(4, 1'b0, "R4 left again");
        stop_run();
    endtask

    task automatic t_polarity();
        left_is_high = 1'b0;
        cyc(1'b0);
        check("R5 idle ws follows polarity", ws, 0);
        begin_run(2, 1'b0, 1'b0);
        measure_half(3, 1'b1, "R5 left low");
        measure_half(3, 1'b0, "R5 right high");
        stop_run();
    endtask

    task automatic t_one_bit();
        logic cs, hs, w;
        bit gap_bad = 1'b0;
        begin_run(0, 1'b0, 1'b1);
        for (int i = 0; i < 3; i++) begin
            bit_step(cs, hs, w, gap_bad);
            check("R7 one-bit chan_start", cs, 1);
            check("R7 one-bit half_strobe", hs, 1);
            check("R3 one-bit ws alternates", w, (i % 2 == 0) ? 0 : 1);
        end
        stop_run();
    endtask

    task automatic t_midframe();
        begin_run(3, 1'b0, 1'b1);
        chan_bits_m1 = CNT_W'(5);
        uneven_en    = 1'b1;
        left_is_high = 1'b0;
        measure_half(4, 1'b0, "R8 current left keeps old");
        measure_half(4, 1'b0, "R8 current right keeps old");
        measure_half(6, 1'b1, "R8 new left");
        measure_half(7, 1'b0, "R8 new right");
        stop_run();
    endtask

    task automatic t_disable();
        logic cs, hs, w;
        bit gap_bad = 1'b0;
        int pulses = 0;
        begin_run(3, 1'b0, 1'b1);
        measure_half(4, 1'b0, "R3 before disable");
        master_en = 1'b0;
        cyc(1'b0);
        check("R10 ws back to left", ws, 1);
        check("R10 pulses low", chan_start | half_strobe, 0);
        for (int i = 0; i < 6; i++) begin
            bit_step(cs, hs, w, gap_bad);
            if (cs || hs || !w) pulses++;
        end
        check("R10 ticks ignored after disable", pulses, 0);
    endtask

    task automatic t_max();
        begin_run(2047, 1'b0, 1'b1);
        measure_half(2048, 1'b0, "R11 max count");
        stop_run();
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_idle();
        t_sym();
        t_uneven();
        t_polarity();
        t_one_bit();
        t_midframe();
        t_disable();
        t_max();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule